// File: doc/BRIEF.md
# 8-bit ALU with flag generation

This block performs one 8-bit arithmetic or logic operation per accepted request and keeps the processor flag byte in a register of its own. A request carries a 4-bit operation code and two operands; the response carries the 8-bit result, the flag byte as it stands after the operation, and a write-enable that tells the caller whether the accumulator should take the result. The flag register is the carry and status source for the next request, so chained add-with-carry or subtract-with-borrow sequences work without the caller returning flags.

Besides the usual carry C, the flag byte holds a second carry copy X with its own update rules, and each operation family leaves selected flags untouched. Flag byte layout (bit 7 down to 0): S, Z, reserved (always 0), H, X, P/V, N, C. The request side is a valid/ready stream; the response side is a one-entry valid/ready register. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high; `in_ready` is high when the response register is empty or is being drained in the same cycle. A response is held unchanged while `out_valid` is high and `out_ready` is low. The flag register updates at request acceptance.

Top module: `alu8_flagged`

## Requirements
- R1: Operation codes: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 compare, 8 increment, 9 decrement; `out_acc_we` is 1 for codes 0 to 6, 8 and 9 and 0 for compare and all other codes.
- R2: Add returns (A+B) mod 256 and add-with-carry (A+B+C) mod 256; both set C and X to the carry out of bit 7 and clear N.
- R3: For the add forms H is the carry out of bit 3 (carry-in included) and P/V (bit 2) is the carry out of bit 7 XOR the carry out of bit 6.
- R4: Subtract returns (A-B) mod 256, sets N, sets H when A[3:0] < B[3:0], sets C when A < B unsigned, sets P/V when the signed difference lies outside -128..127, and sets X on a borrow while keeping the previous X otherwise.
- R5: Subtract-with-borrow uses B+C as the subtrahend for result, H (low nibble of B+C), C and P/V, sets N, and leaves X unchanged.
- R6: Compare produces the same flags as subtract, with N = 1, and does not request an accumulator write.
- R7: AND sets H to 1, OR and XOR clear H; all three clear N, C and X, and set P/V to 1 when the result has an even number of one bits.
- R8: Increment returns A+1 mod 256, sets H when the result's low nibble is 0, sets X when A = 0xFF, sets P/V when A = 0x7F and otherwise keeps P/V, and keeps C and N.
- R9: Decrement returns A-1 mod 256, sets N, sets H when the result's low nibble is 0, sets X when A = 0x00, sets P/V when A = 0x80 and otherwise keeps P/V, and keeps C.
- R10: For every operation that writes the accumulator, S equals result bit 7 and Z is 1 exactly when the result is 0; flag bit 5 is always 0.
- R11: Codes 10 to 15 return A unchanged and leave the whole flag byte unchanged.
- R12: After reset the flag byte is 0x00, `out_valid` is 0 and `in_ready` is 1; the flag register takes the new flags at acceptance, so the next request sees them.
- R13: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and the response outputs stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 8 | First operand (accumulator) |
| in_b | input | 8 | Second operand |
| out_valid | output | 1 | Response present |
| out_ready | input | 1 | Consumer takes the response |
| out_result | output | 8 | Operation result |
| out_flags | output | 8 | Flag byte after the operation |
| out_acc_we | output | 1 | Accumulator should take the result |

## Verification
The assertions watch every cycle for the stream rules (held response, blocked request side), the reserved bit, S and Z agreeing with the written result, the compare write-enable, the AND flag pattern, carry and X retention in increment, decrement and subtract-with-borrow, and pass-through of unknown codes. The arithmetic values of H, C, X and P/V across nibble, sign and wrap boundaries, and carry chaining between consecutive requests, can only be shown by the bench's directed and random scenarios compared against its behavioural model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FLAG_W = 8;

  // operation codes
  localparam logic [3:0] OPC_ADD  = 4'd0;
  localparam logic [3:0] OPC_ADDC = 4'd1;
  localparam logic [3:0] OPC_SUB  = 4'd2;
  localparam logic [3:0] OPC_SUBB = 4'd3;
  localparam logic [3:0] OPC_AND  = 4'd4;
  localparam logic [3:0] OPC_OR   = 4'd5;
  localparam logic [3:0] OPC_XOR  = 4'd6;
  localparam logic [3:0] OPC_CMP  = 4'd7;
  localparam logic [3:0] OPC_INC  = 4'd8;
  localparam logic [3:0] OPC_DEC  = 4'd9;

  // logic unit function select
  localparam logic [1:0] LFN_AND = 2'd0;
  localparam logic [1:0] LFN_OR  = 2'd1;
  localparam logic [1:0] LFN_XOR = 2'd2;

  typedef struct packed {
    logic s;
    logic z;
    logic rsv;
    logic h;
    logic x;
    logic pv;
    logic n;
    logic c;
  } alu_flags_t;

  // one-hot unit select; all zero means pass-through
  typedef struct packed {
    logic arith;
    logic lgc;
    logic step;
  } alu_sel_t;

endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
  import alu8_pkg::*;
(
  input  logic [3:0] op,
  output alu_sel_t   sel,
  output logic       do_sub,
  output logic       use_cin,
  output logic [1:0] lfn,
  output logic       step_dec,
  output logic       acc_we
);

  always_comb begin
    sel      = '0;
    do_sub   = 1'b0;
    use_cin  = 1'b0;
    lfn      = LFN_AND;
    step_dec = 1'b0;
    acc_we   = 1'b0;
    unique case (op)
      OPC_ADD:  begin sel.arith = 1'b1; acc_we = 1'b1; end
      OPC_ADDC: begin sel.arith = 1'b1; use_cin = 1'b1; acc_we = 1'b1; end
      OPC_SUB:  begin sel.arith = 1'b1; do_sub = 1'b1; acc_we = 1'b1; end
      OPC_SUBB: begin sel.arith = 1'b1; do_sub = 1'b1; use_cin = 1'b1; acc_we = 1'b1; end
      OPC_CMP:  begin sel.arith = 1'b1; do_sub = 1'b1; end
      OPC_AND:  begin sel.lgc = 1'b1; lfn = LFN_AND; acc_we = 1'b1; end
      OPC_OR:   begin sel.lgc = 1'b1; lfn = LFN_OR;  acc_we = 1'b1; end
      OPC_XOR:  begin sel.lgc = 1'b1; lfn = LFN_XOR; acc_we = 1'b1; end
      OPC_INC:  begin sel.step = 1'b1; acc_we = 1'b1; end
      OPC_DEC:  begin sel.step = 1'b1; step_dec = 1'b1; acc_we = 1'b1; end
      default:  begin end
    endcase
  end

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          do_sub,
  input  logic          use_cin,
  input  logic          c_in_flag,
  input  logic          x_in_flag,
  output logic [DW-1:0] res,
  output alu_flags_t    fo
);

  localparam int NIB = DW / 2;

  logic          cin;
  logic [DW:0]   sum;
  logic [DW:0]   dsum;
  logic [DW:0]   rhs;
  logic          h_add, v_add, c_next;
  logic          h_sub, v_sub, brw, msb_in_sub;

  always_comb begin
    cin = use_cin & c_in_flag;

    // addition path; internal carries recovered from sum bits
    sum    = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    h_add  = sum[NIB] ^ a[NIB] ^ b[NIB];
    c_next = sum[DW-1] ^ a[DW-1] ^ b[DW-1];
    v_add  = sum[DW] ^ c_next;

    // subtraction as a + ~b + ~cin
    dsum       = {1'b0, a} + {1'b0, ~b} + {{DW{1'b0}}, ~cin};
    msb_in_sub = dsum[DW-1] ^ a[DW-1] ^ ~b[DW-1];
    v_sub      = msb_in_sub ^ dsum[DW];

    // borrow and half borrow against the widened subtrahend
    rhs   = {1'b0, b} + {{DW{1'b0}}, cin};
    brw   = ({1'b0, a} < rhs);
    h_sub = (a[NIB-1:0] < rhs[NIB-1:0]);

    res = do_sub ? dsum[DW-1:0] : sum[DW-1:0];

    fo   = '0;
    fo.s = res[DW-1];
    fo.z = ~|res;
    if (do_sub) begin
      fo.h  = h_sub;
      fo.pv = v_sub;
      fo.n  = 1'b1;
      fo.c  = brw;
      fo.x  = use_cin ? x_in_flag : (x_in_flag | brw);
    end else begin
      fo.h  = h_add;
      fo.pv = v_add;
      fo.c  = sum[DW];
      fo.x  = sum[DW];
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [1:0]    lfn,
  output logic [DW-1:0] res,
  output alu_flags_t    fo
);

  always_comb begin
    unique case (lfn)
      LFN_OR:  res = a | b;
      LFN_XOR: res = a ^ b;
      default: res = a & b;
    endcase
    fo    = '0;
    fo.s  = res[DW-1];
    fo.z  = ~|res;
    fo.h  = (lfn == LFN_AND);
    fo.pv = ~^res;
  end

endmodule

// File: rtl/alu8_step.sv
module alu8_step
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic          dec,
  input  logic          pv_in,
  input  logic          n_in,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output alu_flags_t    fo
);

  localparam int NIB = DW / 2;
  localparam logic [DW-1:0] ONE     = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

  always_comb begin
    res  = dec ? (a - ONE) : (a + ONE);
    fo   = '0;
    fo.s = res[DW-1];
    fo.z = ~|res;
    fo.h = ~|res[NIB-1:0];
    fo.c = c_in;
    if (dec) begin
      fo.x  = ~|a;
      fo.pv = pv_in | (a == NEG_MIN);
      fo.n  = 1'b1;
    end else begin
      fo.x  = &a;
      fo.pv = pv_in | (a == POS_MAX);
      fo.n  = n_in;
    end
  end

endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DW-1:0]     in_a,
  input  logic [DW-1:0]     in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_result,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_acc_we
);

  alu_sel_t   sel;
  logic       do_sub, use_cin, step_dec, acc_we, pass;
  logic [1:0] lfn;

  alu_flags_t flags_q;
  alu_flags_t as_fl, lg_fl, st_fl, nxt_flags;
  logic [DW-1:0] as_res, lg_res, st_res, nxt_res;

  logic          ov_q, we_q, accept;
  logic [DW-1:0] res_q;

  alu8_decode u_dec (
    .op(in_op), .sel(sel), .do_sub(do_sub), .use_cin(use_cin),
    .lfn(lfn), .step_dec(step_dec), .acc_we(acc_we)
  );

  alu8_addsub #(.DW(DW)) u_addsub (
    .a(in_a), .b(in_b), .do_sub(do_sub), .use_cin(use_cin),
    .c_in_flag(flags_q.c), .x_in_flag(flags_q.x),
    .res(as_res), .fo(as_fl)
  );

  alu8_logic #(.DW(DW)) u_logic (
    .a(in_a), .b(in_b), .lfn(lfn), .res(lg_res), .fo(lg_fl)
  );

  alu8_step #(.DW(DW)) u_step (
    .a(in_a), .dec(step_dec), .pv_in(flags_q.pv), .n_in(flags_q.n),
    .c_in(flags_q.c), .res(st_res), .fo(st_fl)
  );

  // AND-OR merge of the one-hot unit outputs
  always_comb begin
    pass      = ~|sel;
    nxt_res   = ({DW{sel.arith}} & as_res) | ({DW{sel.lgc}} & lg_res) |
                ({DW{sel.step}} & st_res)  | ({DW{pass}} & in_a);
    nxt_flags = ({FLAG_W{sel.arith}} & as_fl) | ({FLAG_W{sel.lgc}} & lg_fl) |
                ({FLAG_W{sel.step}} & st_fl)  | ({FLAG_W{pass}} & flags_q);
  end

  assign in_ready = ~ov_q | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      ov_q    <= 1'b0;
      res_q   <= '0;
      we_q    <= 1'b0;
    end else begin
      if (accept) begin
        flags_q <= nxt_flags;
        res_q   <= nxt_res;
        we_q    <= acc_we;
        ov_q    <= 1'b1;
      end else if (out_ready) begin
        ov_q    <= 1'b0;
      end
    end
  end

  assign out_valid  = ov_q;
  assign out_result = res_q;
  assign out_flags  = flags_q;
  assign out_acc_we = we_q;

endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [3:0] in_op,
  input logic [7:0] in_a,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_result,
  input logic [7:0] out_flags,
  input logic       out_acc_we,
  input logic [7:0] flags_q
);

  logic acc;
  assign acc = in_valid && in_ready;

  assert_stall_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
                                $stable(out_flags) && $stable(out_acc_we));

  assert_stall_block_R13: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  assert_rsv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_flags[5]);

  assert_sign_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_acc_we |-> (out_flags[7] == out_result[7]) &&
                                (out_flags[6] == (out_result == 8'h00)));

  assert_cmp_nowrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd7 |=> !out_acc_we && out_flags[1]);

  assert_and_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd4 |=> out_flags[4] && !out_flags[3] && !out_flags[1] && !out_flags[0]);

  assert_step_keep_c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == 4'd8 || in_op == 4'd9) |=> out_flags[0] == $past(flags_q[0]));

  assert_sbc_keep_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 4'd3 |=> out_flags[3] == $past(flags_q[3]));

  assert_unknown_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op > 4'd9 |=> out_result == $past(in_a) &&
                            out_flags == $past(flags_q) && !out_acc_we);

endmodule

bind alu8_flagged alu8_flagged_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_flags(out_flags), .out_acc_we(out_acc_we),
  .flags_q(flags_q)
);

// File: tb/test_alu8_flagged.sv
module test_alu8_flagged;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_result;
  logic [7:0] out_flags;
  logic       out_acc_we;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [7:0] r;
    logic [7:0] f;
    bit         we;
    int         op;
  } exp_t;

  exp_t       expq[$];
  logic [7:0] mdl_flags = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flagged i_alu8_flagged (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags),
    .out_acc_we(out_acc_we)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tag_of(input int op);
    case (op)
      0, 1:    return "R2/R3";
      2:       return "R4";
      3:       return "R5";
      7:       return "R6";
      4, 5, 6: return "R7";
      8:       return "R8";
      9:       return "R9";
      default: return "R11";
    endcase
  endfunction

  // behavioural flag model: S7 Z6 rsv5 H4 X3 PV2 N1 C0
  function automatic void ref_op(input int op, input int a, input int b,
                                 input logic [7:0] f, output logic [7:0] r,
                                 output logic [7:0] nf, output bit we);
    int c, s, cin, sa, sb, sres, op2, lo, lo7;
    c  = f[0];
    sa = (a >= 128) ? a - 256 : a;
    sb = (b >= 128) ? b - 256 : b;
    we = 1;
    nf = f;
    r  = a[7:0];
    if (op == 0 || op == 1) begin
      cin = (op == 1) ? c : 0;
      s   = a + b + cin;
      lo  = (a % 16) + (b % 16) + cin;
      lo7 = (a % 128) + (b % 128) + cin;
      r   = s[7:0];
      nf  = 8'h00;
      nf[4] = (lo > 15);
      nf[0] = (s > 255);
      nf[3] = (s > 255);
      nf[2] = (s > 255) != (lo7 > 127);
    end else if (op == 2 || op == 3 || op == 7) begin
      cin  = (op == 3) ? c : 0;
      op2  = b + cin;
      sres = sa - sb - cin;
      s    = a - op2 + 512;
      r    = s[7:0];
      nf   = 8'h00;
      nf[1] = 1;
      nf[4] = (a % 16) < (op2 % 16);
      nf[0] = (a < op2);
      nf[2] = (sres < -128) || (sres > 127);
      nf[3] = (op == 3) ? f[3] : (f[3] | (a < op2));
      we    = (op != 7);
    end else if (op >= 4 && op <= 6) begin
      if (op == 4) s = a & b; else if (op == 5) s = a | b; else s = a ^ b;
      r  = s[7:0];
      nf = 8'h00;
      nf[4] = (op == 4);
      nf[2] = ($countones(r) % 2) == 0;
    end else if (op == 8) begin
      s  = (a + 1) % 256;
      r  = s[7:0];
      nf[4] = (s % 16) == 0;
      nf[3] = (a == 255);
      nf[2] = f[2] | (a == 127);
    end else if (op == 9) begin
      s  = (a + 255) % 256;
      r  = s[7:0];
      nf[4] = (s % 16) == 0;
      nf[3] = (a == 0);
      nf[2] = f[2] | (a == 128);
      nf[1] = 1;
    end else begin
      we = 0;
    end
    if (op <= 9 && op != 7) begin
      nf[7] = r[7];
      nf[6] = (r == 8'h00);
    end else if (op == 7) begin
      nf[7] = r[7];
      nf[6] = (r == 8'h00);
    end
    nf[5] = 1'b0;
  endfunction

  // one clock of stimulus and comparison, acting at the falling edge
  task automatic cycle(input bit v, input int op, input int a, input int b,
                       input bit rdy, output bit took);
    exp_t e;
    @(negedge clk);
    chk(out_valid == (expq.size() > 0), "R13 out_valid", out_valid, expq.size() > 0);
    out_ready = rdy;
    #1;
    if (out_valid && rdy && expq.size() > 0) begin
      e = expq.pop_front();
      chk(out_result == e.r, {tag_of(e.op), " result"}, out_result, e.r);
      chk(out_flags == e.f, {tag_of(e.op), " flags"}, out_flags, e.f);
      chk(out_acc_we == e.we, "R1 write-enable", out_acc_we, e.we);
      chk(out_flags[5] == 1'b0, "R10 reserved bit", out_flags[5], 0);
    end
    in_valid = v;
    in_op    = op[3:0];
    in_a     = a[7:0];
    in_b     = b[7:0];
    #1;
    took = v && in_ready;
    if (took) begin
      e.op = op;
      ref_op(op, a, b, mdl_flags, e.r, e.f, e.we);
      mdl_flags = e.f;
      expq.push_back(e);
    end
  endtask

  task automatic run_op(input int op, input int a, input int b, input bit rnd_rdy);
    bit took;
    bit rdy;
    do begin
      rdy = rnd_rdy ? (($urandom % 4) != 0) : 1'b1;
      cycle(1'b1, op, a, b, rdy, took);
    end while (!took);
  endtask

  task automatic idle(input int n);
    bit took;
    for (int i = 0; i < n; i++) cycle(1'b0, 0, 0, 0, 1'b1, took);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit took;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_flags == 8'h00, "R12 reset flags", out_flags, 0);
    chk(in_ready == 1'b1, "R12 reset in_ready", in_ready, 1);

    // R12: add-with-carry straight after reset sees C=0
    run_op(1, 8'h10, 8'h20, 0);
    // R2/R3: signed overflow and half carry, then wrap to zero
    run_op(0, 8'h7F, 8'h01, 0);
    run_op(0, 8'hFF, 8'h01, 0);
    // R12: carry from previous request chains into ADC
    run_op(1, 8'h10, 8'h20, 0);
    run_op(1, 8'h80, 8'h80, 0);
    run_op(1, 8'h0F, 8'h00, 0);
    // R4: borrow sets X, then a no-borrow subtract keeps X
    run_op(2, 8'h00, 8'h01, 0);
    run_op(2, 8'h05, 8'h03, 0);
    run_op(2, 8'h80, 8'h01, 0);
    run_op(2, 8'h7F, 8'hFF, 0);
    // R5: borrow chained in, X untouched, subtrahend nibble wrap
    run_op(0, 8'h00, 8'h00, 0);
    run_op(2, 8'h01, 8'h02, 0);
    run_op(3, 8'h20, 8'h0F, 0);
    run_op(3, 8'h00, 8'hFF, 0);
    run_op(3, 8'h80, 8'h00, 0);
    // R6: compare equal and less
    run_op(7, 8'h42, 8'h42, 0);
    run_op(7, 8'h10, 8'h20, 0);
    // R7: logic forms and parity
    run_op(4, 8'h0F, 8'hF0, 0);
    run_op(4, 8'hFF, 8'h81, 0);
    run_op(5, 8'h01, 8'h02, 0);
    run_op(6, 8'hAA, 8'h55, 0);
    run_op(6, 8'h3C, 8'h3C, 0);
    // R8: increment boundaries with C set beforehand
    run_op(0, 8'hFF, 8'h02, 0);
    run_op(8, 8'h7F, 8'h00, 0);
    run_op(8, 8'hFF, 8'h00, 0);
    run_op(8, 8'h0E, 8'h00, 0);
    // R9: decrement boundaries
    run_op(9, 8'h00, 8'h00, 0);
    run_op(9, 8'h80, 8'h00, 0);
    run_op(9, 8'h11, 8'h00, 0);
    // R11: unknown codes
    run_op(10, 8'h5A, 8'h11, 0);
    run_op(15, 8'hC3, 8'hFF, 0);
    idle(2);

    // R13: random back-pressure with random operations
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) cycle(1'b0, 0, 0, 0, ($urandom % 2) == 1, took);
      run_op($urandom % 16, $urandom % 256, $urandom % 256, 1'b1);
    end
    idle(4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule